// File: doc/BRIEF.md
# External Interrupt Input Controller

This block conditions the external interrupt request pins of a small 8-bit microcontroller. Each active-low pin passes through a two-flop synchronizer. A machine-cycle strobe then samples it, once every `CLKS_PER_MC` clocks. A per-channel mode bit selects how the request flag behaves. In level mode the flag follows the most recent sample. In edge mode it latches a high-then-low pair of samples and holds until the CPU acknowledges the vector or software rewrites it.

Each flag is gated by its own channel enable and by a global enable, and the gated flags merge into a single request line to the CPU. A separate wake-up output comes straight from the synchronized pin levels, with no dependence on the sampling strobe. It can therefore lift the core out of idle or power-down while the machine-cycle timing is stopped. Priority resolution and vectoring happen elsewhere.

Top module: `ext_irq_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, all flags, `cpu_irq` and `wake_req` are 0. A pin held low through reset in edge mode does not set its flag, because a first sample cannot form an edge.
- R2: Pins are sampled only once per machine cycle (every `CLKS_PER_MC` = 6 clocks). A low pulse that is gone before the next sample point leaves no trace.
- R3: With the mode bit at 0 (level), the channel's flag is 1 exactly while the latest sample is low and returns to 0 when a high is sampled. Acknowledge and software writes have no effect on it.
- R4: With the mode bit at 1 (edge), the flag is set when one sample reads high and the next reads low, and it stays set after the pin returns high.
- R5: A one-clock acknowledge pulse on an edge-mode channel clears its flag on the following clock edge.
- R6: In level mode a pin still low after acknowledge keeps the flag and `cpu_irq` asserted.
- R7: In edge mode a software write (`flag_wr_en` bit high) loads `flag_wr_data` into that flag on the next clock edge.
- R8: A hardware set event in the same clock as an acknowledge or software clear leaves the flag at 1.
- R9: `cpu_irq` is 1 exactly when `glb_en` is 1 and some channel has both its flag and its `ch_en` bit at 1.
- R10: `wake_req` is 1 whenever `glb_en` is 1 and some enabled channel's synchronized pin is low, in either mode. It appears two clocks after the pin falls and does not wait for a sample strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | NUM_CH | Raw active-low request pins |
| trig_edge | input | NUM_CH | Mode per channel: 0 level, 1 edge |
| ch_en | input | NUM_CH | Per-channel enable |
| glb_en | input | 1 | Global interrupt enable |
| ack | input | NUM_CH | One-clock vector acknowledge per channel |
| flag_wr_en | input | NUM_CH | Software write strobe for the flags |
| flag_wr_data | input | NUM_CH | Value to write into the flags |
| flag_q | output | NUM_CH | Request flag per channel |
| cpu_irq | output | 1 | Combined gated request to the CPU |
| wake_req | output | 1 | Wake-up request for idle and power-down |

## Verification
The bench builds the block with its defaults: two channels and a six-clock machine cycle. With these values it keeps its own clock count in step with the divider phase after reset. That makes two exact timing cases reachable. In one, a one-clock low pulse falls between sample points. In the other, an acknowledge lands in the same clock as the strobe that detects a falling edge. Two channels are enough to cover every combination of the per-channel and global enables in the vector table.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_mode_e;

  // A falling pair of samples counts only once a first sample exists
  function automatic logic fall_seen(input logic primed, input logic prev_s,
                                     input logic new_s);
    return primed & prev_s & ~new_s;
  endfunction

  // Latched flag update: hardware set beats software load beats acknowledge
  function automatic logic next_edge_flag(input logic cur, input logic hw_set,
                                          input logic clr, input logic wr_en,
                                          input logic wr_data);
    if (hw_set) return 1'b1;
    if (wr_en)  return wr_data;
    if (clr)    return 1'b0;
    return cur;
  endfunction

  function automatic logic gate_req(input logic flag, input logic en,
                                    input logic glb);
    return flag & en & glb;
  endfunction

endpackage

// File: rtl/ext_irq_mc_strobe.sv
module ext_irq_mc_strobe #(
  parameter int CLKS_PER_MC = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic mc_strobe
);
  localparam int CW = (CLKS_PER_MC > 1) ? $clog2(CLKS_PER_MC) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_MC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign mc_strobe = (cnt_q == LAST);

  generate
    if (CLKS_PER_MC > 1) begin : g_spacing
      // R2
      strobe_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mc_strobe |=> !mc_strobe);
    end
  endgenerate

endmodule

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-2:0], d};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= d;
      end
    end
  endgenerate

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/ext_irq_channel.sv
module ext_irq_channel
  import ext_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mc_strobe,
  input  logic pin_sync,
  input  logic trig_edge,
  input  logic ack,
  input  logic wr_en,
  input  logic wr_data,
  output logic flag
);
  logic samp_q;
  logic primed_q;
  logic edge_flag_q;
  logic hw_set;
  logic sw_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q   <= 1'b1;
      primed_q <= 1'b0;
    end else if (mc_strobe) begin
      samp_q   <= pin_sync;
      primed_q <= 1'b1;
    end
  end

  assign hw_set = (trig_mode_e'(trig_edge) == TRIG_EDGE) & mc_strobe &
                  fall_seen(primed_q, samp_q, pin_sync);
  assign sw_wr  = wr_en & trig_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_flag_q <= 1'b0;
    else        edge_flag_q <= next_edge_flag(edge_flag_q, hw_set, ack & trig_edge,
                                              sw_wr, wr_data);
  end

  assign flag = trig_edge ? edge_flag_q : ~samp_q;

  // R2
  samp_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mc_strobe |=> $stable(samp_q));

  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_edge && ack && !hw_set && !wr_en) |=> !edge_flag_q);

  // R8
  hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> edge_flag_q);

  // R4
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_set && !sw_wr && !edge_flag_q) |=> !edge_flag_q);

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int CLKS_PER_MC = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] irq_pin_n,
  input  logic [NUM_CH-1:0] trig_edge,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic              glb_en,
  input  logic [NUM_CH-1:0] ack,
  input  logic [NUM_CH-1:0] flag_wr_en,
  input  logic [NUM_CH-1:0] flag_wr_data,
  output logic [NUM_CH-1:0] flag_q,
  output logic              cpu_irq,
  output logic              wake_req
);
  logic              mc_strobe;
  logic [NUM_CH-1:0] pin_sync;
  logic [NUM_CH-1:0] gated;

  ext_irq_mc_strobe #(.CLKS_PER_MC(CLKS_PER_MC)) u_strobe (
    .clk(clk), .rst_n(rst_n), .mc_strobe(mc_strobe)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(irq_pin_n[c]), .q(pin_sync[c])
      );
      ext_irq_channel u_chan (
        .clk(clk), .rst_n(rst_n), .mc_strobe(mc_strobe),
        .pin_sync(pin_sync[c]), .trig_edge(trig_edge[c]), .ack(ack[c]),
        .wr_en(flag_wr_en[c]), .wr_data(flag_wr_data[c]), .flag(flag_q[c])
      );
      assign gated[c] = gate_req(flag_q[c], ch_en[c], glb_en);
    end
  endgenerate

  assign cpu_irq  = |gated;
  assign wake_req = glb_en & |(ch_en & ~pin_sync);

  // R9
  irq_gating_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (glb_en && (|(flag_q & ch_en))));

  // R10
  wake_gating_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (glb_en && (|ch_en)));

endmodule

// File: tb/ext_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module ext_irq_ctrl_tb_top;
  localparam int NCH = 2;
  localparam int MC  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] irq_pin_n = '1;
  logic [NCH-1:0] trig_edge = '0;
  logic [NCH-1:0] ch_en = '0;
  logic glb_en = 1'b0;
  logic [NCH-1:0] ack = '0;
  logic [NCH-1:0] flag_wr_en = '0;
  logic [NCH-1:0] flag_wr_data = '0;
  logic [NCH-1:0] flag_q;
  logic cpu_irq;
  logic wake_req;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  ext_irq_ctrl #(.NUM_CH(NCH), .CLKS_PER_MC(MC)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .trig_edge(trig_edge),
    .ch_en(ch_en), .glb_en(glb_en), .ack(ack), .flag_wr_en(flag_wr_en),
    .flag_wr_data(flag_wr_data), .flag_q(flag_q), .cpu_irq(cpu_irq),
    .wake_req(wake_req)
  );

  // row: pins[8:7] en[6:5] glb[4] exp_flag[3:2] exp_irq[1] exp_wake[0]
  localparam logic [8:0] VEC [8] = '{
    9'b11_11_1_00_0_0,
    9'b10_11_1_01_1_1,
    9'b01_11_1_10_1_1,
    9'b01_01_1_10_0_0,
    9'b10_01_1_01_1_1,
    9'b00_11_0_11_0_0,
    9'b00_10_1_11_1_1,
    9'b11_00_1_00_0_0
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic align(input int phase);
    @(negedge clk);
    while ((cyc % MC) != phase) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    // R1: reset state, pin 0 low through reset in edge mode
    irq_pin_n = 2'b10; trig_edge = 2'b11; ch_en = 2'b11; glb_en = 1'b1;
    tick(3);
    check("R1 flags in reset", flag_q, 2'b00);
    check("R1 irq in reset", cpu_irq, 1'b0);
    check("R1 wake in reset", wake_req, 1'b0);
    rst_n = 1'b1;
    tick(20);
    check("R1 no false edge", flag_q, 2'b00);
    check("R1 irq after reset", cpu_irq, 1'b0);

    // R3 R9 R10: level-mode gating table
    trig_edge = 2'b00;
    irq_pin_n = 2'b11;
    tick(16);
    for (int i = 0; i < 8; i++) begin
      irq_pin_n = VEC[i][8:7];
      ch_en     = VEC[i][6:5];
      glb_en    = VEC[i][4];
      tick(16);
      check("R3 level flag", flag_q, VEC[i][3:2]);
      check("R9 cpu_irq", cpu_irq, VEC[i][1]);
      check("R10 wake", wake_req, VEC[i][0]);
    end

    // R6 R3: level flag ignores ack and writes
    ch_en = 2'b11; glb_en = 1'b1; irq_pin_n = 2'b10;
    tick(16);
    ack = 2'b01; tick(1); ack = 2'b00; tick(1);
    check("R6 level after ack", flag_q[0], 1'b1);
    check("R6 irq after ack", cpu_irq, 1'b1);
    flag_wr_en = 2'b01; flag_wr_data = 2'b00; tick(1); flag_wr_en = 2'b00;
    check("R3 level write ignored", flag_q[0], 1'b1);
    irq_pin_n = 2'b11;
    tick(16);
    check("R3 level follows high", flag_q[0], 1'b0);

    // R4 R5: edge mode latch and acknowledge
    trig_edge = 2'b01;
    tick(16);
    check("R4 edge idle", flag_q[0], 1'b0);
    irq_pin_n = 2'b10; tick(16);
    check("R4 edge set", flag_q[0], 1'b1);
    irq_pin_n = 2'b11; tick(16);
    check("R4 edge held", flag_q[0], 1'b1);
    check("R9 edge irq", cpu_irq, 1'b1);
    ack = 2'b01; tick(1); ack = 2'b00;
    check("R5 ack clears", flag_q[0], 1'b0);

    // R7: software write in edge mode
    flag_wr_en = 2'b01; flag_wr_data = 2'b01; tick(1); flag_wr_en = 2'b00;
    check("R7 write one", flag_q[0], 1'b1);
    flag_wr_en = 2'b01; flag_wr_data = 2'b00; tick(1); flag_wr_en = 2'b00;
    check("R7 write zero", flag_q[0], 1'b0);

    // R2: one-clock low pulse between sample points is missed
    tick(12);
    align(0);
    irq_pin_n = 2'b10;
    @(negedge clk);
    irq_pin_n = 2'b11;
    tick(16);
    check("R2 short pulse unseen", flag_q[0], 1'b0);

    // R8: ack in the same clock as the detecting strobe
    align(2);
    irq_pin_n = 2'b10;
    align(5);
    ack = 2'b01;
    @(negedge clk);
    ack = 2'b00;
    check("R8 set beats ack", flag_q[0], 1'b1);
    irq_pin_n = 2'b11;
    tick(16);
    ack = 2'b01; tick(1); ack = 2'b00;
    check("R5 ack clears again", flag_q[0], 1'b0);

    // R10: wake follows synchronized pin in two clocks, no strobe needed
    ch_en = 2'b10; glb_en = 1'b1; trig_edge = 2'b10;
    tick(16);
    irq_pin_n = 2'b01;
    tick(1);
    check("R10 wake one clock", wake_req, 1'b0);
    tick(1);
    check("R10 wake two clocks", wake_req, 1'b1);
    ch_en = 2'b01; #1;
    check("R10 wake disabled", wake_req, 1'b0);
    irq_pin_n = 2'b11;
    tick(4);

    finish_run();
  end

endmodule